// File: doc/BRIEF.md
# Dual-Product Accumulator with Cascade

This block forms the signed products of two pairs of 12-bit operands, adds or subtracts each one under its own control, and folds the result into a 24-bit running total. A 16-bit cascade word, placed in the top sixteen bits of the total, can also be added to the sum. This lets several blocks be chained, or lets a constant offset be injected. When a new accumulation run starts, a half-LSB rounding term for a 16-bit result can be added once. Every data input and every control is registered and pipelined. A sample taken in one clock is therefore handled as a unit, with the controls that arrived in the same clock.

The data path has six register stages. The stages are: operand capture, multiply, negate-and-sum, round, cascade add, and accumulate. The accumulate stage is a two-state action selector. LOAD is taken when the pipelined accumulate control of that sample is low, and it replaces the total with the new term. ADD is taken when that control is high, and it adds the new term to the total. The selector moves to LOAD or ADD on every clock, following only that control. A fast cascade mode sends the cascade word around the alignment registers. In that mode it reaches the total three clocks after capture instead of six.

Top module: `dual_mac_cascade`

## Requirements
- R1: While `rst_n` is low, every register clears, and `acc_out` reads 0 until new data reaches it.
- R2: Operands are two's complement. After the sixth rising edge following a sample, `acc_out` holds op_a*op_b + op_c*op_d for that sample, reduced modulo 2^24.
- R3: `neg_ab` high subtracts op_a*op_b instead of adding it. `neg_cd` high does the same for op_c*op_d. The two controls act independently.
- R4: When `rnd_en` is high and `acc_en` is low in the same sample, 128 (bit 7 of the 24-bit sum) is added to that sample's term.
- R5: When `acc_en` is high, `rnd_en` has no effect on the result.
- R6: `acc_en` low makes the sample's term replace the total. `acc_en` high adds the term to the total left by the previous sample.
- R7: When `cas_skip` is high, the cascade word of that sample contributes nothing.
- R8: When `cas_skip` and `cas_fast` are both low, the cascade word is added at total bits 23:8 (the word shifted left by 8). It arrives with the six-clock latency of the products captured with it.
- R9: When `cas_fast` is high and `cas_skip` is low, the shifted cascade word is added to the total after the third rising edge, into the term being formed then. Each word is counted exactly once, even when `cas_fast` changes from sample to sample.
- R10: Each control acts only on the sample captured in the same clock, so controls may change on every clock without disturbing neighbouring samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 12 | First multiplicand of product one, signed |
| op_b | input | 12 | Second multiplicand of product one, signed |
| op_c | input | 12 | First multiplicand of product two, signed |
| op_d | input | 12 | Second multiplicand of product two, signed |
| cas_in | input | 16 | Cascade word, added at bits 23:8 |
| neg_ab | input | 1 | Subtract product one |
| neg_cd | input | 1 | Subtract product two |
| rnd_en | input | 1 | Add half-LSB rounding at the start of a run |
| acc_en | input | 1 | High: add to total; low: load total |
| cas_skip | input | 1 | High: ignore the cascade word |
| cas_fast | input | 1 | High: cascade word takes the three-clock path |
| acc_out | output | 24 | Running total |

## Verification
The product sum is tried over every pairing of eight operand values, which include zero, ±1 and both 12-bit extremes. This separates sign handling, the most-negative corner and 24-bit wrap from ordinary magnitudes. Negation is tried with all four sign combinations on the same operands, so an add cannot pass for a subtract. Rounding is tried both at run starts and inside runs, and runs of varying length show whether the total loads or adds at the right sample. Cascade words at their extremes are tried with the word ignored, on the slow path, on the fast path, and with the path toggling every clock. A long pseudo-random stream, in which every control changes each clock, then shows whether any control acts on the wrong sample.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // action the accumulate stage takes for the sample reaching it
    typedef enum logic {
        ACT_LOAD = 1'b0,
        ACT_ADD  = 1'b1
    } acc_act_e;

endpackage

// File: rtl/dmc_delay.sv
module dmc_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/dmc_products.sv
module dmc_products #(
    parameter int OP_W  = 12,
    parameter int SUM_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OP_W-1:0]  a,
    input  logic signed [OP_W-1:0]  b,
    input  logic signed [OP_W-1:0]  c,
    input  logic signed [OP_W-1:0]  d,
    input  logic                    neg1,
    input  logic                    neg2,
    output logic signed [SUM_W-1:0] sum_s3
);
    localparam int P_W = 2 * OP_W;

    logic signed [OP_W-1:0] a_q, b_q, c_q, d_q;
    logic                   n1_q, n2_q, n1_p, n2_p;
    logic signed [P_W-1:0]  p1, p2;
    logic signed [SUM_W-1:0] e1, e2, t1, t2;

    // stage 1: capture operands and sign controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0;
            n1_q <= 1'b0; n2_q <= 1'b0;
        end else begin
            a_q <= a; b_q <= b; c_q <= c; d_q <= d;
            n1_q <= neg1; n2_q <= neg2;
        end
    end

    // stage 2: multiply
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1 <= '0; p2 <= '0; n1_p <= 1'b0; n2_p <= 1'b0;
        end else begin
            p1 <= a_q * b_q;
            p2 <= c_q * d_q;
            n1_p <= n1_q;
            n2_p <= n2_q;
        end
    end

    always_comb begin
        e1 = SUM_W'(p1);
        e2 = SUM_W'(p2);
        t1 = n1_p ? -e1 : e1;
        t2 = n2_p ? -e2 : e2;
    end

    // stage 3: signed sum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_s3 <= '0;
        else        sum_s3 <= t1 + t2;
    end

    // R2: zero operands in both pairs give a zero sum two clocks later
    a_r2_zero_products: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_q == 0 || b_q == 0) && (c_q == 0 || d_q == 0)) |=> ##1 (sum_s3 == 0));

    // R3: with both products equal, opposite signs cancel
    a_r3_opposite_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (p1 == p2 && n1_p != n2_p) |=> (sum_s3 == 0));
endmodule

// File: rtl/dmc_accum.sv
module dmc_accum
    import dmc_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int CAS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] sum_s3,
    input  logic                    rnd_s3,
    input  logic                    acc_s3,
    input  logic [CAS_W-1:0]        cas_s1,
    input  logic                    skip_s1,
    input  logic                    fast_s1,
    input  logic [CAS_W-1:0]        cas_s4,
    input  logic                    skip_s4,
    input  logic                    fast_s4,
    output logic [ACC_W-1:0]        total
);
    localparam int SHIFT   = ACC_W - CAS_W;
    localparam int RND_BIT = SHIFT - 1;

    logic [ACC_W-1:0] r_s4, x_s5, round_add, slow_term, fast_term;
    logic             acc_s4, acc_s5;
    acc_act_e         act;

    always_comb begin
        round_add = (rnd_s3 && !acc_s3) ? (ACC_W'(1) << RND_BIT) : '0;
        slow_term = (!fast_s4 && !skip_s4) ? (ACC_W'(cas_s4) << SHIFT) : '0;
        fast_term = (fast_s1 && !skip_s1) ? (ACC_W'(cas_s1) << SHIFT) : '0;
    end

    // stage 4: rounding on the first term of a run only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_s4 <= '0; acc_s4 <= 1'b0;
        end else begin
            r_s4   <= ACC_W'(sum_s3) + round_add;
            acc_s4 <= acc_s3;
        end
    end

    // stage 5: cascade add, from the aligned or the fast path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_s5 <= '0; acc_s5 <= 1'b0;
        end else begin
            x_s5   <= r_s4 + slow_term + fast_term;
            acc_s5 <= acc_s4;
        end
    end

    // stage 6: action selector
    always_comb begin
        act = acc_s5 ? ACT_ADD : ACT_LOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: total <= x_s5;
                ACT_ADD:  total <= total + x_s5;
                default:  total <= x_s5;
            endcase
        end
    end

    // R4: a rounded run start of a zero sum yields exactly bit 7
    a_r4_round_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_s3 && !acc_s3 && sum_s3 == 0) |=> (r_s4 == (ACC_W'(1) << RND_BIT)));

    // R5: inside a run the sum passes the round stage unchanged
    a_r5_no_round_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        acc_s3 |=> (r_s4 == ACC_W'($past(sum_s3))));

    // R7: no enabled cascade word on either path leaves the term untouched
    a_r7_skip_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ((skip_s4 || fast_s4) && !(fast_s1 && !skip_s1)) |=> (x_s5 == $past(r_s4)));

    // R6: adding a zero term in a run keeps the total
    a_r6_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_s5 && x_s5 == 0) |=> $stable(total));
endmodule

// File: rtl/dual_mac_cascade.sv
module dual_mac_cascade #(
    parameter int OP_W  = 12,
    parameter int CAS_W = 16,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [OP_W-1:0] op_a,
    input  logic signed [OP_W-1:0] op_b,
    input  logic signed [OP_W-1:0] op_c,
    input  logic signed [OP_W-1:0] op_d,
    input  logic [CAS_W-1:0]       cas_in,
    input  logic                   neg_ab,
    input  logic                   neg_cd,
    input  logic                   rnd_en,
    input  logic                   acc_en,
    input  logic                   cas_skip,
    input  logic                   cas_fast,
    output logic [ACC_W-1:0]       acc_out
);
    localparam int PROD_STAGES = 3;
    localparam int CAS_LATE    = PROD_STAGES;
    localparam int CAS_REC_W   = CAS_W + 2;

    logic signed [ACC_W-1:0] sum_s3;
    logic [1:0]              ctl_s3;
    logic [CAS_REC_W-1:0]    cas_rec1, cas_rec4;

    dmc_products #(.OP_W(OP_W), .SUM_W(ACC_W)) u_prod (
        .clk(clk), .rst_n(rst_n),
        .a(op_a), .b(op_b), .c(op_c), .d(op_d),
        .neg1(neg_ab), .neg2(neg_cd),
        .sum_s3(sum_s3)
    );

    // round and accumulate controls, aligned to the sum
    dmc_delay #(.W(2), .DEPTH(PROD_STAGES)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({rnd_en, acc_en}), .q(ctl_s3)
    );

    // cascade record: capture stage, then alignment stages
    dmc_delay #(.W(CAS_REC_W), .DEPTH(1)) u_cas_in (
        .clk(clk), .rst_n(rst_n),
        .d({cas_fast, cas_skip, cas_in}), .q(cas_rec1)
    );

    dmc_delay #(.W(CAS_REC_W), .DEPTH(CAS_LATE)) u_cas_align (
        .clk(clk), .rst_n(rst_n),
        .d(cas_rec1), .q(cas_rec4)
    );

    dmc_accum #(.ACC_W(ACC_W), .CAS_W(CAS_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .sum_s3(sum_s3),
        .rnd_s3(ctl_s3[1]), .acc_s3(ctl_s3[0]),
        .cas_s1(cas_rec1[CAS_W-1:0]),
        .skip_s1(cas_rec1[CAS_W]), .fast_s1(cas_rec1[CAS_W+1]),
        .cas_s4(cas_rec4[CAS_W-1:0]),
        .skip_s4(cas_rec4[CAS_W]), .fast_s4(cas_rec4[CAS_W+1]),
        .total(acc_out)
    );
endmodule

// File: tb/dual_mac_cascade_test.sv
`timescale 1ns/1ps
module dual_mac_cascade_test;
    localparam int NS = 680;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [11:0] op_a, op_b, op_c, op_d;
    logic [15:0] cas_in;
    logic neg_ab, neg_cd, rnd_en, acc_en, cas_skip, cas_fast;
    logic [23:0] acc_out;

    always #2 clk = ~clk;

    dual_mac_cascade uut (
        .clk(clk), .rst_n(rst_n),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .cas_in(cas_in), .neg_ab(neg_ab), .neg_cd(neg_cd),
        .rnd_en(rnd_en), .acc_en(acc_en), .cas_skip(cas_skip),
        .cas_fast(cas_fast), .acc_out(acc_out)
    );

    int sa[NS], sb[NS], sc[NS], sd[NS], scs[NS];
    bit n1[NS], n2[NS], rn[NS], ac[NS], sk[NS], ft[NS];
    string tg[NS];
    logic [23:0] ex[NS+1];
    logic [31:0] rs = 32'h1ACE_B00C;
    int checks = 0, fails = 0;
    bit finished = 0;

    function automatic int pick(int i);
        case (i % 8)
            0: return 0;
            1: return 1;
            2: return -1;
            3: return 2047;
            4: return -2048;
            5: return 3;
            6: return -700;
            default: return 1234;
        endcase
    endfunction

    task automatic step();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
    endtask

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: acc_out=%06h expected %06h", req, act, exp);
        end
    endtask

    task automatic put(input int k, input string t);
        step();
        sa[k] = pick(k); sb[k] = pick(k / 8); sc[k] = pick(k + 1); sd[k] = pick(k / 8 + 2);
        n1[k] = 0; n2[k] = 0; rn[k] = 0; ac[k] = 0; sk[k] = 1; ft[k] = 0;
        scs[k] = int'(rs[15:0]);
        tg[k] = t;
    endtask

    initial begin
        int k;
        k = 0;
        for (int i = 0; i < 64; i++) begin put(k, "R2"); k++; end
        for (int i = 0; i < 64; i++) begin put(k, "R3"); n1[k] = i[0]; n2[k] = i[1]; k++; end
        for (int i = 0; i < 32; i++) begin put(k, "R4"); rn[k] = 1; n1[k] = rs[20]; k++; end
        for (int i = 0; i < 32; i++) begin put(k, "R5"); rn[k] = 1; ac[k] = (i % 4) != 0; k++; end
        for (int i = 0; i < 64; i++) begin put(k, "R6"); ac[k] = (i % 5) != 0; n2[k] = rs[3]; k++; end
        for (int i = 0; i < 32; i++) begin put(k, "R7"); sk[k] = 1; ft[k] = rs[9]; k++; end
        for (int i = 0; i < 64; i++) begin
            put(k, "R8"); sk[k] = 0;
            if (i % 4 == 0) scs[k] = 16'h8000;
            if (i % 4 == 1) scs[k] = 16'hFFFF;
            if (i % 4 == 2) scs[k] = 16'h7FFF;
            ac[k] = (i % 3) == 2;
            k++;
        end
        for (int i = 0; i < 64; i++) begin
            put(k, "R9"); sk[k] = 0;
            ft[k] = (i < 32) ? 1'b1 : rs[7];
            ac[k] = (i % 6) == 5;
            k++;
        end
        for (int i = 0; i < 256; i++) begin
            put(k, "R10");
            sa[k] = int'($signed(rs[11:0])); sc[k] = int'($signed(rs[31:20]));
            step();
            sb[k] = int'($signed(rs[11:0])); sd[k] = int'($signed(rs[31:20]));
            n1[k] = rs[12]; n2[k] = rs[13]; rn[k] = rs[14]; ac[k] = rs[15];
            sk[k] = rs[16]; ft[k] = rs[17];
            k++;
        end
        for (int i = 0; i < 8; i++) begin
            put(k, "R2"); sa[k] = 0; sc[k] = 0; k++;
        end

        op_a = '0; op_b = '0; op_c = '0; op_d = '0; cas_in = '0;
        neg_ab = 0; neg_cd = 0; rnd_en = 0; acc_en = 0; cas_skip = 0; cas_fast = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int t = 0; t <= NS; t++) begin
            int i, j, term;
            bit load;
            if (t > 0) @(negedge clk);
            i = t - 6; j = t - 3; term = 0; load = 1;
            if (i >= 0) begin
                term = (n1[i] ? -1 : 1) * sa[i] * sb[i] + (n2[i] ? -1 : 1) * sc[i] * sd[i];
                if (rn[i] && !ac[i]) term += 128;
                if (!ft[i] && !sk[i]) term += scs[i] << 8;
                load = !ac[i];
            end
            if (j >= 0 && j < NS && ft[j] && !sk[j]) term += scs[j] << 8;
            ex[t] = load ? 24'(term) : 24'(ex[t-1] + 24'(term));
            check(acc_out, ex[t], (t == 0) ? "R1" : (i >= 0 ? tg[i] : "R9"));
            if (t < NS) begin
                op_a = 12'(sa[t]); op_b = 12'(sb[t]); op_c = 12'(sc[t]); op_d = 12'(sd[t]);
                cas_in = 16'(scs[t]);
                neg_ab = n1[t]; neg_cd = n2[t]; rnd_en = rn[t]; acc_en = ac[t];
                cas_skip = sk[t]; cas_fast = ft[t];
            end
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule